// File: doc/BRIEF.md
# Command Post and Reply Queue Register Block

This block sits between a host register bus and the command engine of a storage controller. The host posts 32-bit command addresses by writing one register. Each write lands in a request queue, and the command engine drains that queue through a valid/ready port. The engine returns finished work by pushing 32-bit completion tags into a reply queue. The host takes them out one at a time by reading a single register: each such read removes the entry it returns.

An empty reply queue reads back as all ones, so host software can loop on that register until it sees the sentinel. A level interrupt tells the host that replies are waiting. One mask bit can silence the interrupt. The status register still shows the pending condition whatever the mask says. A doorbell register and a scratchpad complete the map. Reading the scratchpad has no side effect, so the host can read it to flush its posted writes.

Every access takes the same handshake: the host raises the select, and the block answers with a one-cycle ready. Read data is valid during that ready cycle.

Top module: `hq_top`

## Requirements
- R1: After reset, bus_ready, irq and cmd_valid are low, cpl_ready is high, the doorbell output is zero, the status register (offset 0x30) reads 0 and the mask register (offset 0x34) reads 0x00000008.
- R2: A write to offset 0x40 appends the write data to the request queue. cmd_valid/cmd_addr then present the entries oldest first, and each entry is consumed on a cycle with cmd_valid and cmd_ready both high.
- R3: A write to offset 0x40 while the request queue holds REQ_DEPTH entries is discarded. It sets status bit 0, which stays set until reset.
- R4: A read of offset 0x44 returns the oldest completion tag and removes it from the reply queue.
- R5: A read of offset 0x44 while the reply queue is empty returns 0xFFFFFFFF and changes no state.
- R6: The mask register (offset 0x34) reads back the full 32-bit value last written to it.
- R7: Status bit 3 (0x08) is set while the reply queue is not empty, whatever the mask value.
- R8: irq is high exactly when the reply queue is not empty and mask bit 3 is clear.
- R9: The scratchpad (offset 0xB0) reads back the value last written, and reading it changes nothing.
- R10: The doorbell register (offset 0x20) reads back the value last written and drives it on ring_bits.
- R11: A read of an unmapped offset returns 0. A write to an unmapped offset, or to the read-only status register, changes nothing.
- R12: bus_ready rises in the cycle after bus_sel is raised and stays high for exactly one cycle. Each access acts only once.
- R13: cpl_ready is low exactly while the reply queue holds RPL_DEPTH entries, and a tag offered while it is low is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle access completion |
| cmd_valid | output | 1 | Request queue holds an entry |
| cmd_addr | output | 32 | Oldest posted command address |
| cmd_ready | input | 1 | Engine takes the presented entry |
| cpl_valid | input | 1 | Engine offers a completion tag |
| cpl_tag | input | 32 | Completion tag |
| cpl_ready | output | 1 | Reply queue can accept a tag |
| ring_bits | output | 32 | Current doorbell value |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its defaults: four request entries, four reply entries and an 8-bit offset. At these small depths a few writes are enough to fill the request queue and reach the dropped-write path and the sticky overflow bit. A few pushes likewise fill the reply queue, which exercises backpressure and draining down to the empty sentinel. Queue order, the mask/status split and the behaviour of the interrupt can all be seen within a short run.

// File: rtl/hq_pkg.sv
package hq_pkg;

  localparam logic [15:0] OFF_DOORBELL = 16'h0020;
  localparam logic [15:0] OFF_STATUS   = 16'h0030;
  localparam logic [15:0] OFF_MASK     = 16'h0034;
  localparam logic [15:0] OFF_REQ      = 16'h0040;
  localparam logic [15:0] OFF_RPL      = 16'h0044;
  localparam logic [15:0] OFF_SCRATCH  = 16'h00B0;

  localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;
  localparam logic [31:0] MASK_RESET = 32'h0000_0008;
  localparam int          PEND_BIT   = 3;
  localparam int          OVF_BIT    = 0;

  typedef enum logic [2:0] {
    RID_NONE,
    RID_DOORBELL,
    RID_STATUS,
    RID_MASK,
    RID_REQ,
    RID_RPL,
    RID_SCRATCH
  } reg_id_e;

  // Offset to register identity; anything not listed is unmapped.
  function automatic reg_id_e decode_reg(input logic [15:0] off);
    reg_id_e id;
    case (off)
      OFF_DOORBELL: id = RID_DOORBELL;
      OFF_STATUS:   id = RID_STATUS;
      OFF_MASK:     id = RID_MASK;
      OFF_REQ:      id = RID_REQ;
      OFF_RPL:      id = RID_RPL;
      OFF_SCRATCH:  id = RID_SCRATCH;
      default:      id = RID_NONE;
    endcase
    return id;
  endfunction

  // Packs the status word from its two flags.
  function automatic logic [31:0] status_word(input logic pending, input logic ovf);
    logic [31:0] w;
    w = '0;
    w[PEND_BIT] = pending;
    w[OVF_BIT]  = ovf;
    return w;
  endfunction

  // Interrupt line: replies waiting and the reply bit not masked.
  function automatic logic irq_level(input logic pending, input logic [31:0] mask);
    return pending && !mask[PEND_BIT];
  endfunction

endpackage

// File: rtl/hq_fifo.sv
module hq_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign count   = wr_ptr - rd_ptr;
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + CW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= push_data;
  end

endmodule

// File: rtl/hq_irq.sv
module hq_irq
  import hq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mask_we,
  input  logic [31:0] wdata,
  input  logic        ovf_set,
  input  logic        rpl_nonempty,
  output logic [31:0] mask_q,
  output logic [31:0] status_q,
  output logic        ovf_q,
  output logic        irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= MASK_RESET;
      ovf_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata;
      if (ovf_set) ovf_q  <= 1'b1;
    end
  end

  assign status_q = status_word(rpl_nonempty, ovf_q);
  assign irq      = irq_level(rpl_nonempty, mask_q);

endmodule

// File: rtl/hq_plainregs.sv
module hq_plainregs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        db_we,
  input  logic        sp_we,
  input  logic [31:0] wdata,
  output logic [31:0] db_q,
  output logic [31:0] sp_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q <= '0;
      sp_q <= '0;
    end else begin
      if (db_we) db_q <= wdata;
      if (sp_we) sp_q <= wdata;
    end
  end

endmodule

// File: rtl/hq_top.sv
module hq_top
  import hq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REQ_DEPTH = 4,
  parameter int RPL_DEPTH = 4,
  localparam int REQ_CW = ((REQ_DEPTH > 1) ? $clog2(REQ_DEPTH) : 1) + 1,
  localparam int RPL_CW = ((RPL_DEPTH > 1) ? $clog2(RPL_DEPTH) : 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              cmd_valid,
  output logic [31:0]       cmd_addr,
  input  logic              cmd_ready,
  input  logic              cpl_valid,
  input  logic [31:0]       cpl_tag,
  output logic              cpl_ready,
  output logic [31:0]       ring_bits,
  output logic              irq
);

  // Named internal events, also observed by the checker.
  logic        acc_fire;
  reg_id_e     acc_id;
  logic        wr_fire, rd_fire;
  logic        req_push, req_ovf, req_pop;
  logic        rpl_push, rpl_pop;
  logic        req_empty, req_full, rpl_empty, rpl_full;
  logic [31:0] req_head, rpl_head;
  logic [REQ_CW-1:0] req_count;
  logic [RPL_CW-1:0] rpl_count;
  logic [31:0] mask_q, status_q, db_q, sp_q;
  logic        ovf_q;
  logic [31:0] rd_mux;

  assign acc_fire = bus_sel && !bus_ready;
  assign acc_id   = decode_reg(16'(bus_addr));
  assign wr_fire  = acc_fire && bus_wr;
  assign rd_fire  = acc_fire && !bus_wr;

  assign req_push = wr_fire && (acc_id == RID_REQ) && !req_full;
  assign req_ovf  = wr_fire && (acc_id == RID_REQ) && req_full;
  assign req_pop  = cmd_valid && cmd_ready;
  assign rpl_push = cpl_valid && cpl_ready;
  assign rpl_pop  = rd_fire && (acc_id == RID_RPL) && !rpl_empty;

  hq_fifo #(.DEPTH(REQ_DEPTH), .WIDTH(32)) u_req_q (
    .clk(clk), .rst_n(rst_n),
    .push(req_push), .push_data(bus_wdata),
    .pop(req_pop), .head(req_head),
    .empty(req_empty), .full(req_full), .count(req_count)
  );

  hq_fifo #(.DEPTH(RPL_DEPTH), .WIDTH(32)) u_rpl_q (
    .clk(clk), .rst_n(rst_n),
    .push(rpl_push), .push_data(cpl_tag),
    .pop(rpl_pop), .head(rpl_head),
    .empty(rpl_empty), .full(rpl_full), .count(rpl_count)
  );

  hq_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .mask_we(wr_fire && (acc_id == RID_MASK)),
    .wdata(bus_wdata),
    .ovf_set(req_ovf),
    .rpl_nonempty(!rpl_empty),
    .mask_q(mask_q), .status_q(status_q), .ovf_q(ovf_q), .irq(irq)
  );

  hq_plainregs u_plain (
    .clk(clk), .rst_n(rst_n),
    .db_we(wr_fire && (acc_id == RID_DOORBELL)),
    .sp_we(wr_fire && (acc_id == RID_SCRATCH)),
    .wdata(bus_wdata),
    .db_q(db_q), .sp_q(sp_q)
  );

  always_comb begin
    case (acc_id)
      RID_DOORBELL: rd_mux = db_q;
      RID_STATUS:   rd_mux = status_q;
      RID_MASK:     rd_mux = mask_q;
      RID_RPL:      rd_mux = rpl_empty ? EMPTY_WORD : rpl_head;
      RID_SCRATCH:  rd_mux = sp_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= acc_fire;
      bus_rdata <= rd_fire ? rd_mux : '0;
    end
  end

  assign cmd_valid = !req_empty;
  assign cmd_addr  = req_head;
  assign cpl_ready = !rpl_full;
  assign ring_bits = db_q;

endmodule

// File: rtl/hq_chk.sv
module hq_chk
  import hq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REQ_DEPTH = 4,
  parameter int RPL_DEPTH = 4,
  localparam int REQ_CW = ((REQ_DEPTH > 1) ? $clog2(REQ_DEPTH) : 1) + 1,
  localparam int RPL_CW = ((RPL_DEPTH > 1) ? $clog2(RPL_DEPTH) : 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_ready,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic              irq,
  input logic              acc_fire,
  input logic              ovf_q,
  input logic [REQ_CW-1:0] req_count,
  input logic [RPL_CW-1:0] rpl_count
);

  logic rpl_read;
  assign rpl_read = acc_fire && !bus_wr && (16'(bus_addr) == OFF_RPL);

  // R12
  ready_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  // R12
  ready_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_ready) |=> bus_ready);

  // R5
  empty_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_read && rpl_count == '0) |=> (bus_rdata == EMPTY_WORD));

  // R4
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_read && rpl_count != '0 && !(cpl_valid && cpl_ready))
      |=> (rpl_count == $past(rpl_count) - RPL_CW'(1)));

  // R8
  irq_needs_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rpl_count != '0));

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R3
  req_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_count <= REQ_CW'(REQ_DEPTH));

  // R13
  cpl_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_ready |-> (rpl_count == RPL_CW'(RPL_DEPTH)));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !bus_wr && decode_reg(16'(bus_addr)) == RID_NONE) |=> (bus_rdata == '0));

endmodule

bind hq_top hq_chk #(
  .ADDR_W(ADDR_W), .REQ_DEPTH(REQ_DEPTH), .RPL_DEPTH(RPL_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
  .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .irq(irq),
  .acc_fire(acc_fire), .ovf_q(ovf_q),
  .req_count(req_count), .rpl_count(rpl_count)
);

// File: tb/hq_top_tb.sv
module hq_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        cmd_valid;
  logic [31:0] cmd_addr;
  logic        cmd_ready = 1'b0;
  logic        cpl_valid = 1'b0;
  logic [31:0] cpl_tag = '0;
  logic        cpl_ready;
  logic [31:0] ring_bits;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hq_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_ready(cmd_ready), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .cpl_ready(cpl_ready), .ring_bits(ring_bits), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus access; ready is checked in its cycle and after.
  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    check("R12 ready", {31'b0, bus_ready}, 32'd1);
    rd = bus_rdata;
    bus_sel = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    check("R12 ready one cycle", {31'b0, bus_ready}, 32'd0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] unused;
    access(1'b1, a, d, unused);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    access(1'b0, a, 32'h0, v);
  endtask

  task automatic push_tag(input logic [31:0] t);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_tag = t;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic take_cmd(input string req, input logic [31:0] exp);
    @(negedge clk);
    check(req, {31'b0, cmd_valid}, 32'd1);
    check(req, cmd_addr, exp);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 ready", {31'b0, bus_ready}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 cmd_valid", {31'b0, cmd_valid}, 0);
    check("R1 cpl_ready", {31'b0, cpl_ready}, 1);
    check("R1 ring_bits", ring_bits, 0);
    rd(8'h34, v); check("R1 mask reset", v, 32'h8);
    rd(8'h30, v); check("R1 status reset", v, 32'h0);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(8'hB0, 32'hA5A5_1234);
    rd(8'hB0, v); check("R9 scratch", v, 32'hA5A5_1234);
    rd(8'hB0, v); check("R9 scratch reread", v, 32'hA5A5_1234);
    wr(8'h20, 32'h0000_00C3);
    check("R10 ring_bits", ring_bits, 32'hC3);
    rd(8'h20, v); check("R10 doorbell read", v, 32'hC3);
    wr(8'h34, 32'hDEAD_0008);
    rd(8'h34, v); check("R6 mask readback", v, 32'hDEAD_0008);
    wr(8'h34, 32'h8);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h10, 32'h1111_2222);
    rd(8'h10, v); check("R11 unmapped read", v, 0);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); check("R11 status write ignored", v, 0);
    rd(8'hB0, v); check("R11 scratch untouched", v, 32'hA5A5_1234);
    check("R11 no request", {31'b0, cmd_valid}, 0);
  endtask

  task automatic t_reply();
    logic [31:0] v;
    rd(8'h44, v); check("R5 empty sentinel", v, 32'hFFFF_FFFF);
    push_tag(32'h0000_0101);
    push_tag(32'h0000_0202);
    check("R8 masked irq", {31'b0, irq}, 0);
    rd(8'h30, v); check("R7 pending while masked", v, 32'h8);
    wr(8'h34, 32'h0);
    check("R8 unmasked irq", {31'b0, irq}, 1);
    rd(8'h44, v); check("R4 first tag", v, 32'h101);
    check("R8 irq still", {31'b0, irq}, 1);
    rd(8'h44, v); check("R4 second tag", v, 32'h202);
    check("R8 irq drop", {31'b0, irq}, 0);
    rd(8'h44, v); check("R5 drained sentinel", v, 32'hFFFF_FFFF);
    rd(8'h30, v); check("R7 status clear", v, 0);
  endtask

  task automatic t_reply_full();
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) push_tag(32'h0000_A000 + i);
    check("R13 cpl_ready low", {31'b0, cpl_ready}, 0);
    push_tag(32'h0000_BEEF);
    check("R8 irq with full", {31'b0, irq}, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h44, v); check("R13 order after full", v, 32'h0000_A000 + i);
    end
    rd(8'h44, v); check("R13 extra tag not stored", v, 32'hFFFF_FFFF);
    check("R13 cpl_ready back", {31'b0, cpl_ready}, 1);
  endtask

  task automatic t_request();
    wr(8'h40, 32'h1000_0000);
    wr(8'h40, 32'h1000_0040);
    wr(8'h40, 32'h1000_0080);
    take_cmd("R2 first", 32'h1000_0000);
    take_cmd("R2 second", 32'h1000_0040);
    take_cmd("R2 third", 32'h1000_0080);
    check("R2 empty after drain", {31'b0, cmd_valid}, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    rd(8'h30, v); check("R3 no overflow yet", v, 0);
    for (int i = 0; i < DEPTH; i++) wr(8'h40, 32'h2000_0000 + i);
    wr(8'h40, 32'h0BAD_0BAD);
    rd(8'h30, v); check("R3 overflow flag", v, 32'h1);
    for (int i = 0; i < DEPTH; i++) take_cmd("R3 kept entries", 32'h2000_0000 + i);
    check("R3 dropped write absent", {31'b0, cmd_valid}, 0);
    rd(8'h30, v); check("R3 flag sticky", v, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_unmapped();
    t_reply();
    t_reply_full();
    t_request();
    t_overflow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule